// File: doc/BRIEF.md
# Master Reset Sequencer

This block combines every reset cause of a small 4-bit microcontroller into one master reset that no enable bit can mask. The causes are a power-on strobe, a brown-out comparator trip, a watchdog expiry, an active-low external reset pin and a clock-supervisor fault. The asynchronous causes pass through two-flop synchronisers. The power-on strobe asserts reset asynchronously and is released synchronously. After the last active cause goes away, reset is held for a parameterised number of ticks of a clock that runs at one quarter of the system clock. A new cause at any point reloads that hold.

While reset is held, the block clears the interrupt enable, pending and active state, puts the peripheral bus into its reset mode and forces all bidirectional ports to input. On release it hands the core one injected instruction fetch: a short call opcode aimed at the reset vector. After that single fetch the core's own fetch path takes over. A brown-out trip is ignored only when the core is asleep and the peripheral clock is stopped at the same time. A one-bit threshold select for the brown-out comparator is writable outside reset and returns to its default during reset. A sticky cause register lets the reset routine find out what caused the reset.

Top module: `mrst_ctrl`

## Requirements
- R1: `core_rst` is high while `por_n` is low, and it rises asynchronously on the falling edge of `por_n`. It is also high whenever a brown-out, watchdog, external-pin or clock-fault request is present and not masked. No input can suppress it.
- R2: A request input that rises before clock edge k is seen through a two-stage synchroniser. `core_rst` is high after edge k+2.
- R3: Once every request is gone, `core_rst` stays high for exactly 4*STRETCH system-clock cycles, counted from the first edge at which the synchronised request is low. The hold counter advances only on every fourth system clock.
- R4: A request that arrives while the hold is running reloads the full hold length.
- R5: A brown-out request (`bod_trip`) is ignored only while `core_sleep` and `pclk_stopped` are both high. In every other case it resets.
- R6: `intc_clr`, `iobus_rst` and `port_dir_in` are high exactly when `core_rst` is high.
- R7: `bod_thr_sel` takes value BOT_DEFAULT (0) at any edge where `core_rst` is high. Outside reset, a write through `bot_we`/`bot_wdata` takes effect at the next edge.
- R8: In the cycle where `core_rst` falls, `inj_valid` rises with `inj_opcode` = C1h and `inj_addr` = 008h. It stays high until the first edge with `fetch_ack` high and then drops. Both fields read zero while `inj_valid` is low.
- R9: `rst_cause` is set to 00001b by power-on. Bit 1 (brown-out, only when unmasked), bit 2 (watchdog), bit 3 (external pin) and bit 4 (clock fault) are set by the matching synchronised request. Only power-on clears the register.
- R10: The external reset pin `ext_rst_n` is active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on strobe, active low, asynchronous |
| bod_trip | input | 1 | Brown-out comparator output, asynchronous |
| wdt_expire | input | 1 | Watchdog timeout, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| clk_fault | input | 1 | Clock supervisor fault, asynchronous |
| core_sleep | input | 1 | Core is in sleep |
| pclk_stopped | input | 1 | Peripheral clock stopped |
| bot_we | input | 1 | Threshold select write strobe |
| bot_wdata | input | 1 | Threshold select write value |
| fetch_ack | input | 1 | Core consumed the injected fetch |
| core_rst | output | 1 | Master reset to core |
| intc_clr | output | 1 | Clear interrupt enable/pending/active |
| iobus_rst | output | 1 | Peripheral bus control in reset mode |
| port_dir_in | output | 1 | Force bidirectional ports to input |
| bod_thr_sel | output | 1 | Brown-out threshold select to comparator |
| inj_valid | output | 1 | Injected fetch present |
| inj_opcode | output | 8 | Injected opcode (C1h when valid) |
| inj_addr | output | 12 | Call target (008h when valid) |
| rst_cause | output | 5 | Sticky reset cause bits |

## Verification
The bench targets a request that arrives in the middle of a running hold. A design that does not reload the hold would release reset early. It checks a brown-out during sleep alone, during a stopped clock alone, and during both. A mask decoded from only one condition would either drop a real reset or reset a chip that is powered down. It measures the release cycle exactly, so an error in the divider phase or an off-by-one in the counter shows up as a shifted fall of `core_rst` or of the injection. It also acknowledges the injected call on random cycles: a sequencer that re-injects or drops the call would show a wrong `inj_valid`. A threshold bit that is not forced during reset would leak into `bod_thr_sel`.

// File: rtl/mrst_pkg.sv
package mrst_pkg;
  localparam int NSRC    = 4;
  localparam int SRC_BOD = 0;
  localparam int SRC_WDT = 1;
  localparam int SRC_EXT = 2;
  localparam int SRC_CLK = 3;
  localparam int CAUSE_W = NSRC + 1;
  localparam logic [7:0]  CALL_OPCODE  = 8'hC1;
  localparam logic [11:0] RESET_VECTOR = 12'h008;

  // Fold newly seen requests into the sticky cause; bit 0 belongs to power-on.
  function automatic logic [CAUSE_W-1:0] cause_merge(input logic [CAUSE_W-1:0] cur,
                                                     input logic [NSRC-1:0] hit);
    return cur | {hit, 1'b0};
  endfunction
endpackage

// File: rtl/mrst_sync.sv
module mrst_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/mrst_stretch.sv
module mrst_stretch #(
  parameter int STRETCH = 8,
  parameter int DIV     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic active,
  output logic release_now
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam int DW = $clog2(DIV);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);

  logic [CW-1:0] cnt;
  logic [DW-1:0] div;
  logic          tick;

  function automatic logic [CW-1:0] next_cnt(input logic r, input logic t,
                                             input logic [CW-1:0] c);
    if (r) return LOAD;
    if (t && c != '0) return c - 1'b1;
    return c;
  endfunction

  assign tick        = (div == DW'(DIV - 1));
  assign active      = (cnt != '0);
  assign release_now = !req && tick && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= LOAD;
      div <= '0;
    end else begin
      cnt <= next_cnt(req, tick, cnt);
      div <= req ? '0 : div + 1'b1;
    end
  end

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> cnt == LOAD);
  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !tick) |=> cnt == $past(cnt));
  assert_release_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |=> !active);
endmodule

// File: rtl/mrst_inject.sv
module mrst_inject
  import mrst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_reset,
  input  logic        req,
  input  logic        release_now,
  input  logic        fetch_ack,
  output logic        valid,
  output logic [7:0]  opcode,
  output logic [11:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 valid <= 1'b0;
    else if (release_now)       valid <= 1'b1;
    else if (in_reset || req)   valid <= 1'b0;
    else if (fetch_ack)         valid <= 1'b0;
  end

  assign opcode = valid ? CALL_OPCODE  : 8'h00;
  assign addr   = valid ? RESET_VECTOR : 12'h000;

  assert_no_inject_on_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !valid);
  assert_single_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && fetch_ack && !in_reset && !req) |=> !valid);
endmodule

// File: rtl/mrst_ctrl.sv
module mrst_ctrl
  import mrst_pkg::*;
#(
  parameter int   STRETCH     = 8,
  parameter logic BOT_DEFAULT = 1'b0
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               bod_trip,
  input  logic               wdt_expire,
  input  logic               ext_rst_n,
  input  logic               clk_fault,
  input  logic               core_sleep,
  input  logic               pclk_stopped,
  input  logic               bot_we,
  input  logic               bot_wdata,
  input  logic               fetch_ack,
  output logic               core_rst,
  output logic               intc_clr,
  output logic               iobus_rst,
  output logic               port_dir_in,
  output logic               bod_thr_sel,
  output logic               inj_valid,
  output logic [7:0]         inj_opcode,
  output logic [11:0]        inj_addr,
  output logic [CAUSE_W-1:0] rst_cause
);
  logic [NSRC-1:0] raw, sync_q, hit;
  logic            bod_mask, req_any, stretch_on, release_now;

  assign raw[SRC_BOD] = bod_trip;
  assign raw[SRC_WDT] = wdt_expire;
  assign raw[SRC_EXT] = ~ext_rst_n;
  assign raw[SRC_CLK] = clk_fault;

  mrst_sync #(.W(NSRC)) u_sync (.clk(clk), .rst_n(por_n), .d(raw), .q(sync_q));

  assign bod_mask = core_sleep & pclk_stopped;
  always_comb begin
    hit          = sync_q;
    hit[SRC_BOD] = sync_q[SRC_BOD] & ~bod_mask;
  end
  assign req_any = |hit;

  mrst_stretch #(.STRETCH(STRETCH), .DIV(4)) u_stretch (
    .clk(clk), .rst_n(por_n), .req(req_any),
    .active(stretch_on), .release_now(release_now));

  assign core_rst    = !por_n || stretch_on;
  assign intc_clr    = core_rst;
  assign iobus_rst   = core_rst;
  assign port_dir_in = core_rst;

  mrst_inject u_inject (
    .clk(clk), .rst_n(por_n), .in_reset(stretch_on), .req(req_any),
    .release_now(release_now), .fetch_ack(fetch_ack),
    .valid(inj_valid), .opcode(inj_opcode), .addr(inj_addr));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          bod_thr_sel <= BOT_DEFAULT;
    else if (stretch_on) bod_thr_sel <= BOT_DEFAULT;
    else if (bot_we)     bod_thr_sel <= bot_wdata;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rst_cause <= CAUSE_W'(1);
    else        rst_cause <= cause_merge(rst_cause, hit);
  end

  assert_thr_default_R7: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |=> bod_thr_sel == BOT_DEFAULT);
  assert_bod_masked_R5: assert property (@(posedge clk) disable iff (!por_n)
    (sync_q[SRC_BOD] && bod_mask && sync_q[NSRC-1:1] == '0 && !core_rst) |=> !core_rst);
  assert_cause_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    (rst_cause & $past(rst_cause)) == $past(rst_cause));
endmodule

// File: tb/mrst_ctrl_tb_top.sv
module mrst_ctrl_tb_top;
  localparam int S = 8;
  localparam int HOLD = 4 * S;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic bod_trip = 0, wdt_expire = 0, ext_rst_n = 1, clk_fault = 0;
  logic core_sleep = 0, pclk_stopped = 0, bot_we = 0, bot_wdata = 0, fetch_ack = 0;
  logic core_rst, intc_clr, iobus_rst, port_dir_in, bod_thr_sel, inj_valid;
  logic [7:0] inj_opcode;
  logic [11:0] inj_addr;
  logic [4:0] rst_cause;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  mrst_ctrl #(.STRETCH(S), .BOT_DEFAULT(1'b0)) dut_i (
    .clk(clk), .por_n(por_n), .bod_trip(bod_trip), .wdt_expire(wdt_expire),
    .ext_rst_n(ext_rst_n), .clk_fault(clk_fault), .core_sleep(core_sleep),
    .pclk_stopped(pclk_stopped), .bot_we(bot_we), .bot_wdata(bot_wdata),
    .fetch_ack(fetch_ack), .core_rst(core_rst), .intc_clr(intc_clr),
    .iobus_rst(iobus_rst), .port_dir_in(port_dir_in), .bod_thr_sel(bod_thr_sel),
    .inj_valid(inj_valid), .inj_opcode(inj_opcode), .inj_addr(inj_addr),
    .rst_cause(rst_cause));

  // Reference model, written from the requirements in clock-cycle terms.
  logic [3:0] m_s1, m_s2;
  int         m_hold;
  logic       m_inj, m_bot;
  logic [4:0] m_cause;

  function automatic logic [3:0] live_req(input logic [3:0] s, input logic slp, input logic stp);
    logic [3:0] r = s;
    if (slp && stp) r[0] = 1'b0;
    return r;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_s1 <= '0; m_s2 <= '0; m_hold <= HOLD; m_inj <= 0; m_bot <= 0; m_cause <= 5'b00001;
    end else begin
      logic [3:0] r;
      r = live_req(m_s2, core_sleep, pclk_stopped);
      if (r != 0)          m_hold <= HOLD;
      else if (m_hold > 0) m_hold <= m_hold - 1;
      if (r != 0)          m_inj <= 0;
      else if (m_hold == 1) m_inj <= 1;
      else if (m_hold > 0) m_inj <= 0;
      else if (fetch_ack)  m_inj <= 0;
      if (m_hold > 0)  m_bot <= 0;
      else if (bot_we) m_bot <= bot_wdata;
      m_cause <= m_cause | {r, 1'b0};
      m_s2 <= m_s1;
      m_s1 <= {clk_fault, ~ext_rst_n, wdt_expire, bod_trip};
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic er;
    cyc++;
    er = !por_n || (m_hold > 0);
    chk(core_rst === er, "R1 R2 R3 R4 R5 core_rst", core_rst, er);
    chk(intc_clr === er && iobus_rst === er && port_dir_in === er, "R6 periph reset",
        {intc_clr, iobus_rst, port_dir_in}, {er, er, er});
    chk(bod_thr_sel === m_bot, "R7 threshold select", bod_thr_sel, m_bot);
    chk(inj_valid === m_inj, "R8 inject valid", inj_valid, m_inj);
    chk(inj_opcode === (m_inj ? 8'hC1 : 8'h00) && inj_addr === (m_inj ? 12'h008 : 12'h000),
        "R8 inject fields", {inj_opcode, inj_addr}, m_inj ? 20'hC1008 : 20'h0);
    chk(rst_cause === m_cause, "R9 R10 cause", rst_cause, m_cause);
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    void'($urandom(32'd4242));
    step(3);
    por_n = 1;                        // R1: release power-on
    step(HOLD + 6);
    fetch_ack = 1; step(1); fetch_ack = 0; step(3);   // R8 single fetch
    ext_rst_n = 0; step(3); ext_rst_n = 1;            // R10 active-low pin
    step(12);
    wdt_expire = 1; step(1); wdt_expire = 0;          // R4 reload mid-hold
    step(HOLD + 8);
    core_sleep = 1; pclk_stopped = 1;                 // R5 masked brown-out
    bod_trip = 1; step(10); bod_trip = 0; step(4);
    pclk_stopped = 0; bod_trip = 1; step(2); bod_trip = 0;  // R5 sleep only: resets
    step(HOLD + 8);
    core_sleep = 0; pclk_stopped = 1; bod_trip = 1; step(2); bod_trip = 0;
    step(HOLD + 8);
    bot_we = 1; bot_wdata = 1; step(1); bot_we = 0;   // R7 write outside reset
    clk_fault = 1; step(2); clk_fault = 0;            // R7 forced back during reset
    step(HOLD + 8);
    for (int i = 0; i < 4000; i++) begin
      if (bod_trip)   bod_trip   = ($urandom % 4) != 0; else bod_trip   = ($urandom % 90) == 0;
      if (wdt_expire) wdt_expire = ($urandom % 4) != 0; else wdt_expire = ($urandom % 120) == 0;
      if (!ext_rst_n) ext_rst_n  = ($urandom % 4) == 0; else ext_rst_n  = ($urandom % 150) != 0;
      if (clk_fault)  clk_fault  = ($urandom % 4) != 0; else clk_fault  = ($urandom % 150) == 0;
      if (($urandom % 25) == 0) core_sleep   = ~core_sleep;
      if (($urandom % 25) == 0) pclk_stopped = ~pclk_stopped;
      fetch_ack = ($urandom % 3) == 0;
      bot_we    = ($urandom % 6) == 0;
      bot_wdata = 1'($urandom);
      if (i == 2000) begin por_n = 0; step(2); por_n = 1; end
      step(1);
    end
    bod_trip = 0; wdt_expire = 0; ext_rst_n = 1; clk_fault = 0; fetch_ack = 0; bot_we = 0;
    step(HOLD + 10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule